// File: doc/BRIEF.md
# Configuration Stream Descrambler and Bit-Bang Serializer

This block sits between a byte source that delivers a scrambled configuration image and the pins that load a programmable device serially. For each accepted input byte, a 32-bit keystream register first advances through a nonlinear update. The update adds a constant, reduces the sum modulo 177, and adds the product of the old state and a second constant. The byte is then XORed with the low eight bits of the new state.

The descrambled byte leaves the block in one of two forms, chosen per byte by a mode input sampled with that byte. In pass mode it is emitted unchanged as a single output byte. In expand mode it becomes sixteen output bytes that drive a serial configuration port. Each data bit, most significant first, produces one byte with the clock line high, then one with the clock line low. Both ends of the block are valid/ready byte streams.

The modulo reduction is computed a few bits per cycle. While it runs, the input is not ready. A restart input returns the keystream to its seed so that a new image can be streamed without a full reset.

Top module: `cfg_descrambler`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The keystream register starts at 0x3f6df2ab. It changes only when an input byte is accepted, and then becomes ((s + 0x0a853753) mod 177) + s × 0x08034052, with all arithmetic 32-bit and wrapping.
- R3: The descrambled value of a byte is the input byte XOR bits 7:0 of the updated keystream. In pass mode exactly one output byte with this value is produced.
- R4: In expand mode one input byte produces exactly 16 output bytes, two per data bit, most significant data bit first. The first byte of a pair has bit 6 equal to the data bit and bit 0 equal to 1. The second has bit 6 equal to the data bit and bit 0 equal to 0. All other bits are 0.
- R5: `in_expand` is sampled together with each accepted byte (1 = expand, 0 = pass). Consecutive bytes may use different modes.
- R6: In the cycle after a byte is accepted, `in_ready` is 0. It stays 0 until that byte's keystream reduction has completed, so only one byte is being descrambled at a time.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` unchanged.
- R8: A one-cycle `restart` pulse returns the keystream to the seed. It discards any byte being descrambled or serialized, so no output byte from it appears, and the next accepted byte is descrambled as the first byte after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Return keystream to seed and discard in-flight data |
| in_valid | input | 1 | Scrambled byte is offered |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Scrambled byte |
| in_expand | input | 1 | Mode for this byte: 1 expand, 0 pass |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Descrambled byte or bit-bang pattern |

## Verification
The hardest condition to reach from the ports is a restart that lands while a byte is part-way through its multi-cycle reduction, or while an expanded byte is only partly serialized. In both cases the discarded work must leave no trace in the output or the keystream. The bench reaches these states by timing the restart pulse a fixed number of cycles after a handshake, and by consuming only a few bit-bang bytes before pulsing it. It then checks that the output stays silent and that the next byte decodes against the seed. A sweep of all 256 input values under changing backpressure covers the keystream sequence, and a byte-by-byte mode alternation covers per-byte mode capture.

// File: rtl/cfgsd_pkg.sv
package cfgsd_pkg;
  typedef logic [31:0] word_t;
  typedef logic [7:0]  byte_t;

  typedef enum logic [1:0] {
    KG_IDLE = 2'd0,
    KG_CALC = 2'd1,
    KG_DONE = 2'd2
  } kg_phase_e;

  typedef enum logic {
    EMIT_PASS   = 1'b0,
    EMIT_EXPAND = 1'b1
  } emit_mode_e;
endpackage

// File: rtl/cfgsd_keystream.sv
module cfgsd_keystream
  import cfgsd_pkg::*;
#(
  parameter word_t       SEED      = 32'h3f6df2ab,
  parameter word_t       ADD_K     = 32'h0a853753,
  parameter word_t       MUL_K     = 32'h08034052,
  parameter int unsigned MODULUS   = 177,
  parameter int unsigned STEP_BITS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       acc_valid,
  output logic       acc_ready,
  input  byte_t      acc_data,
  input  emit_mode_e acc_mode,
  output logic       res_valid,
  input  logic       res_take,
  output byte_t      res_data,
  output emit_mode_e res_mode
);
  localparam int unsigned N_STEPS = 32 / STEP_BITS;
  localparam int unsigned CNT_W   = $clog2(N_STEPS + 1);
  localparam int unsigned REM_W   = $clog2(MODULUS) + 1;

  word_t            state_q;
  word_t            divd_q;
  word_t            prod_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_nx;
  logic [CNT_W-1:0] cnt_q;
  byte_t            data_q;
  emit_mode_e       mode_q;
  kg_phase_e        phase_q;
  word_t            state_nx;

  assign acc_ready = (phase_q == KG_IDLE) && !res_valid;
  assign state_nx  = prod_q + 32'(rem_q);

  // restoring reduction, STEP_BITS dividend bits per cycle
  always_comb begin
    logic [REM_W-1:0] r_v;
    r_v = rem_q;
    for (int i = 0; i < int'(STEP_BITS); i++) begin
      r_v = {r_v[REM_W-2:0], divd_q[31-i]};
      if (r_v >= REM_W'(MODULUS)) r_v = r_v - REM_W'(MODULUS);
    end
    rem_nx = r_v;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state_q   <= SEED;
      divd_q    <= '0;
      prod_q    <= '0;
      rem_q     <= '0;
      cnt_q     <= '0;
      data_q    <= '0;
      mode_q    <= EMIT_PASS;
      phase_q   <= KG_IDLE;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_mode  <= EMIT_PASS;
    end else begin
      if (res_valid && res_take) res_valid <= 1'b0;
      unique case (phase_q)
        KG_IDLE: if (acc_valid && acc_ready) begin
          divd_q  <= state_q + ADD_K;
          prod_q  <= state_q * MUL_K;
          rem_q   <= '0;
          cnt_q   <= '0;
          data_q  <= acc_data;
          mode_q  <= acc_mode;
          phase_q <= KG_CALC;
        end
        KG_CALC: begin
          rem_q  <= rem_nx;
          divd_q <= divd_q << STEP_BITS;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(N_STEPS - 1)) phase_q <= KG_DONE;
        end
        KG_DONE: begin
          state_q   <= state_nx;
          res_data  <= data_q ^ state_nx[7:0];
          res_mode  <= mode_q;
          res_valid <= 1'b1;
          phase_q   <= KG_IDLE;
        end
        default: phase_q <= KG_IDLE;
      endcase
    end
  end

  // R2: the partial remainder never reaches the modulus
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q != KG_IDLE) |-> (rem_q < REM_W'(MODULUS)));
  // R6: a handshake closes the input on the next cycle
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_ready && !restart) |=> !acc_ready);
  // R8: restart brings the keystream back to the seed
  assert_seed_after_restart_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (state_q == SEED) && !res_valid);
endmodule

// File: rtl/cfgsd_bitbang.sv
module cfgsd_bitbang
  import cfgsd_pkg::*;
#(
  parameter int unsigned BITS     = 8,
  parameter int unsigned DATA_BIT = 6,
  parameter int unsigned CLK_BIT  = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       in_valid,
  output logic       in_ready,
  input  byte_t      in_data,
  input  emit_mode_e in_mode,
  output logic       out_valid,
  input  logic       out_ready,
  output byte_t      out_data
);
  localparam int unsigned PULSES = 2 * BITS;
  localparam int unsigned CNT_W  = $clog2(PULSES);
  localparam int unsigned IDX_W  = $clog2(BITS);

  logic             busy_q;
  byte_t            byte_q;
  emit_mode_e       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             advance;
  logic [IDX_W-1:0] bit_idx;
  byte_t            pattern;
  logic             last;

  assign in_ready = !busy_q;
  assign advance  = !out_valid || out_ready;
  assign bit_idx  = IDX_W'(BITS - 1) - cnt_q[CNT_W-1:1];
  assign last     = (mode_q == EMIT_PASS) || (cnt_q == CNT_W'(PULSES - 1));

  always_comb begin
    pattern           = '0;
    pattern[DATA_BIT] = byte_q[bit_idx];
    pattern[CLK_BIT]  = ~cnt_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      busy_q    <= 1'b0;
      byte_q    <= '0;
      mode_q    <= EMIT_PASS;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (advance) begin
        if (busy_q) begin
          out_valid <= 1'b1;
          out_data  <= (mode_q == EMIT_PASS) ? byte_q : pattern;
          if (last) busy_q <= 1'b0;
          else      cnt_q  <= cnt_q + 1'b1;
        end else begin
          out_valid <= 1'b0;
        end
      end
      if (in_valid && in_ready) begin
        busy_q <= 1'b1;
        byte_q <= in_data;
        mode_q <= in_mode;
        cnt_q  <= '0;
      end
    end
  end

  // R7: a stalled output byte is held
  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !restart) |=> (out_valid && $stable(out_data)));
  // R8: restart empties the output register
  assert_flush_restart_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> !out_valid && !busy_q);
endmodule

// File: rtl/cfg_descrambler.sv
module cfg_descrambler
  import cfgsd_pkg::*;
#(
  parameter word_t       SEED      = 32'h3f6df2ab,
  parameter word_t       ADD_K     = 32'h0a853753,
  parameter word_t       MUL_K     = 32'h08034052,
  parameter int unsigned MODULUS   = 177,
  parameter int unsigned STEP_BITS = 4,
  parameter int unsigned DATA_BIT  = 6,
  parameter int unsigned CLK_BIT   = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_expand,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  logic       mid_valid;
  logic       mid_ready;
  byte_t      mid_data;
  emit_mode_e mid_mode;
  emit_mode_e in_mode;

  assign in_mode = in_expand ? EMIT_EXPAND : EMIT_PASS;

  cfgsd_keystream #(
    .SEED(SEED), .ADD_K(ADD_K), .MUL_K(MUL_K),
    .MODULUS(MODULUS), .STEP_BITS(STEP_BITS)
  ) u_keys (
    .clk(clk), .rst(rst), .restart(restart),
    .acc_valid(in_valid), .acc_ready(in_ready),
    .acc_data(in_data), .acc_mode(in_mode),
    .res_valid(mid_valid), .res_take(mid_ready),
    .res_data(mid_data), .res_mode(mid_mode)
  );

  cfgsd_bitbang #(
    .BITS(8), .DATA_BIT(DATA_BIT), .CLK_BIT(CLK_BIT)
  ) u_bang (
    .clk(clk), .rst(rst), .restart(restart),
    .in_valid(mid_valid), .in_ready(mid_ready),
    .in_data(mid_data), .in_mode(mid_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: tb/cfg_descrambler_test.sv
module cfg_descrambler_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       restart = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_expand = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  int tests = 0;
  int fails = 0;
  int stall_ctr = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  logic [31:0] ks;

  always #10 clk = ~clk;

  cfg_descrambler uut (
    .clk(clk), .rst(rst), .restart(restart),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_expand(in_expand),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] ks_next(input logic [31:0] s);
    logic [31:0] a;
    logic [31:0] m;
    a = s + 32'h0a853753;
    m = s * 32'h08034052;
    return (a % 32'd177) + m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic m);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = b;
    in_expand = m;
    for (int i = 0; i < 200 && !in_ready; i++) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 in_ready low after accept", {31'b0, in_ready}, 32'd0);
  endtask

  task automatic recv(input string req, input logic [7:0] exp);
    bit got;
    got = 1'b0;
    for (int i = 0; i < 300 && !got; i++) begin
      @(negedge clk);
      out_ready = stall_en ? ((stall_ctr % 3) != 1) : 1'b1;
      stall_ctr++;
      if (out_valid && !out_ready) begin
        logic [7:0] held;
        held = out_data;
        @(negedge clk);
        check("R7 held while stalled", {23'b0, out_valid, out_data}, {23'b0, 1'b1, held});
        out_ready = 1'b1;
      end
      if (out_valid && out_ready) begin
        check(req, {24'b0, out_data}, {24'b0, exp});
        got = 1'b1;
      end
    end
    if (!got) check({req, " no output"}, 32'd0, 32'd1);
  endtask

  task automatic quiet(input string req, input int n);
    bit seen;
    seen = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    check(req, {31'b0, seen}, 32'd0);
  endtask

  task automatic byte_pass(input logic [7:0] b);
    ks = ks_next(ks);
    send(b, 1'b0);
    recv("R3 pass byte", b ^ ks[7:0]);
  endtask

  task automatic byte_expand(input logic [7:0] b);
    logic [7:0] d;
    ks = ks_next(ks);
    d  = b ^ ks[7:0];
    send(b, 1'b1);
    for (int k = 7; k >= 0; k--) begin
      recv("R4 clock-high byte", {1'b0, d[k], 5'b0, 1'b1});
      recv("R4 clock-low byte",  {1'b0, d[k], 6'b0});
    end
  endtask

  task automatic pulse_restart;
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    ks = 32'h3f6df2ab;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    ks = 32'h3f6df2ab;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 in_ready after reset", {31'b0, in_ready}, 32'd1);
    check("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);

    // R2 R3: full sweep of byte values, with and without backpressure
    for (int v = 0; v < 256; v++) begin
      stall_en = (v >= 128);
      byte_pass(8'(v));
      if (v == 255) quiet("R3 single byte per input", 20);
    end

    // R4: expansion with backpressure
    stall_en = 1'b1;
    for (int v = 0; v < 6; v++) byte_expand(8'(v * 37 + 5));

    // R5: mode changes byte by byte
    stall_en = 1'b0;
    for (int v = 0; v < 8; v++) begin
      if (v % 2 == 0) byte_expand(8'(v * 11));
      else            byte_pass(8'(v * 11));
    end

    // R2: idle gap does not advance the keystream
    repeat (50) @(negedge clk);
    byte_pass(8'h5a);

    // R8: restart during the reduction
    send(8'h33, 1'b0);
    @(negedge clk);
    pulse_restart();
    quiet("R8 no output after restart in reduction", 40);
    check("R8 in_ready after restart", {31'b0, in_ready}, 32'd1);
    byte_pass(8'hc4);
    byte_pass(8'h19);

    // R8: restart in the middle of serialization
    ks = ks_next(ks);
    send(8'h81, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      for (int j = 0; j < 60 && !out_valid; j++) @(negedge clk);
    end
    out_ready = 1'b0;
    pulse_restart();
    quiet("R8 no output after restart in serialization", 40);
    byte_expand(8'h7e);
    byte_pass(8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule